// File: doc/BRIEF.md
# Tick-Driven System Timer with Single Compare Match

This block is a system timer peripheral that sits on a simple 32-bit register bus. A wide free-running counter advances by one on every clock cycle in which the tick-enable input is high. The counter is split into a low word and a high word, and software reads them as two separate registers. No snapshot is taken between the two reads. To detect a carry that lands between the two accesses, software reads the high word, then the low word, then the high word again, and retries if the two high-word reads differ.

A single compare register is checked only against the low word of the counter. When compare is enabled and the low word equals the compare value on a ticking cycle, a sticky match flag is set. The level interrupt output follows that flag until software writes a one to the flag bit. The flag and the compare-enable bit share one control/status register, so a single write can acknowledge the match and disarm the compare. Because only the low word is compared, a match recurs each time the low word wraps, as long as compare stays enabled.

Bus reads are registered. When the read strobe is high at a clock edge, read data takes the selected register value at that edge and holds it until the next read. All register state is cleared by an asynchronous active-low reset, whose release is synchronised to the clock inside the block.

Top module: `tick_compare_timer`

## Requirements
- R1: After reset, the counter, the compare register, the compare-enable bit and the match flag are zero, `irq` is low and `bus_rdata` is zero.
- R2: The counter (low word LO_W bits, high word HI_W bits) increments by one at each clock edge where `tick_en` is high and holds otherwise. A low-word wrap carries into the high word at the same edge, and the whole counter wraps from all ones to zero.
- R3: When `bus_rd` is high at an edge, `bus_rdata` takes the register at `bus_addr` as it was before that edge: offset 0x04 returns the low word and 0x08 returns the high word, both zero-extended. Without `bus_rd`, `bus_rdata` holds its value.
- R4: The compare register at offset 0x0C is written and read through the bus. Only its low LO_W bits are stored, and the upper bits read as zero.
- R5: The control/status register is at offset 0x00. Bit 4 is the compare enable, which can be written and read back. Bit 0 reads as the match flag. All other bits read as zero.
- R6: The match flag is set at an edge where `tick_en` is high, compare is enabled, and the low word equals the compare value (values taken before the edge).
- R7: While compare is disabled, the match flag is never set.
- R8: `irq` equals the match flag. The flag stays set until a write to offset 0x00 with bit 0 set; a write with bit 0 clear leaves it unchanged.
- R9: If a match and a flag-clearing write fall on the same edge, the flag ends set.
- R10: A single write of 0x1 to offset 0x00 both clears the flag and disables compare.
- R11: Writes to offsets 0x04, 0x08 and to unmapped offsets change no state. Reads of unmapped offsets return zero.
- R12: With compare left enabled, a match recurs after exactly 2^LO_W further ticks, once the low word has wrapped back to the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Counter advance enable, one count per high cycle |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BUS_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | BUS_W | Registered read data |
| irq | output | 1 | Level interrupt, high while the match flag is set |

## Verification
The assertions take for granted that every input is a known level sampled at the rising edge. They also assume that a write and a match that fall on one edge are both judged on the register values from before that edge, and that `bus_addr` carries an exact byte offset, so any other value counts as unmapped. The stimulus changes inputs only on falling edges and never leaves them undriven. Its random addresses are drawn from the four mapped offsets and from arbitrary 8-bit values, so the unmapped space and misaligned offsets are exercised without breaking those assumptions. The bench narrows the counter words so that low-word and full-counter wraps happen within the run.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int OFF_CTL = 'h00;
  localparam int OFF_LO  = 'h04;
  localparam int OFF_HI  = 'h08;
  localparam int OFF_CMP = 'h0C;

  localparam int CTL_FLAG_BIT = 0;
  localparam int CTL_EN_BIT   = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTL,
    SEL_LO,
    SEL_HI,
    SEL_CMP
  } reg_sel_e;
endpackage

// File: rtl/tct_rst_sync.sv
module tct_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int LO_W = 32,
  parameter int HI_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  output logic [LO_W-1:0] cnt_lo,
  output logic [HI_W-1:0] cnt_hi
);
  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [LO_W:0]   lo_sum;
  logic            lo_carry;

  always_comb begin
    lo_sum   = {1'b0, lo_q} + {{LO_W{1'b0}}, 1'b1};
    lo_carry = lo_sum[LO_W];
    lo_d     = lo_q;
    hi_d     = hi_q;
    if (tick_en) begin
      lo_d = lo_sum[LO_W-1:0];
      hi_d = hi_q + HI_W'(lo_carry);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_lo = lo_q;
  assign cnt_hi = hi_q;
endmodule

// File: rtl/tct_match.sv
module tct_match #(
  parameter int LO_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic [LO_W-1:0] cnt_lo,
  input  logic            ctl_wr,
  input  logic            cmp_wr,
  input  logic            wr_clr,
  input  logic            wr_en,
  input  logic [LO_W-1:0] wr_cmp,
  output logic [LO_W-1:0] cmp_q,
  output logic            en_q,
  output logic            flag_q
);
  logic [LO_W-1:0] cmp_d;
  logic            en_d;
  logic            flag_d;
  logic            hit;
  logic            clr;

  always_comb begin
    hit    = tick_en & en_q & (cnt_lo == cmp_q);
    clr    = ctl_wr & wr_clr;
    cmp_d  = cmp_wr ? wr_cmp : cmp_q;
    en_d   = ctl_wr ? wr_en : en_q;
    flag_d = hit | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/tct_regif.sv
module tct_regif
  import tct_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32,
  parameter int LO_W   = 32,
  parameter int HI_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [LO_W-1:0]   cnt_lo,
  input  logic [HI_W-1:0]   cnt_hi,
  input  logic [LO_W-1:0]   cmp_q,
  input  logic              en_q,
  input  logic              flag_q,
  output logic              ctl_wr,
  output logic              cmp_wr,
  output logic [BUS_W-1:0]  bus_rdata
);
  reg_sel_e         sel;
  logic [BUS_W-1:0] ctl_view;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] rdata_q, rdata_d;

  always_comb begin
    if      (bus_addr == ADDR_W'(OFF_CTL)) sel = SEL_CTL;
    else if (bus_addr == ADDR_W'(OFF_LO))  sel = SEL_LO;
    else if (bus_addr == ADDR_W'(OFF_HI))  sel = SEL_HI;
    else if (bus_addr == ADDR_W'(OFF_CMP)) sel = SEL_CMP;
    else                                   sel = SEL_NONE;
  end

  assign ctl_wr = bus_wr & (sel == SEL_CTL);
  assign cmp_wr = bus_wr & (sel == SEL_CMP);

  always_comb begin
    ctl_view               = '0;
    ctl_view[CTL_FLAG_BIT] = flag_q;
    ctl_view[CTL_EN_BIT]   = en_q;
    case (sel)
      SEL_CTL: rd_mux = ctl_view;
      SEL_LO:  rd_mux = BUS_W'(cnt_lo);
      SEL_HI:  rd_mux = BUS_W'(cnt_hi);
      SEL_CMP: rd_mux = BUS_W'(cmp_q);
      default: rd_mux = '0;
    endcase
    rdata_d = bus_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer
  import tct_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32,
  parameter int LO_W   = 32,
  parameter int HI_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic            rst_sync_n;
  logic [LO_W-1:0] cnt_lo;
  logic [HI_W-1:0] cnt_hi;
  logic [LO_W-1:0] cmp_q;
  logic            en_q;
  logic            flag_q;
  logic            ctl_wr;
  logic            cmp_wr;
  logic            unused_wdata;

  assign unused_wdata = ^bus_wdata;

  tct_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tct_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_en (tick_en),
    .cnt_lo  (cnt_lo),
    .cnt_hi  (cnt_hi)
  );

  tct_match #(.LO_W(LO_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_en (tick_en),
    .cnt_lo  (cnt_lo),
    .ctl_wr  (ctl_wr),
    .cmp_wr  (cmp_wr),
    .wr_clr  (bus_wdata[CTL_FLAG_BIT]),
    .wr_en   (bus_wdata[CTL_EN_BIT]),
    .wr_cmp  (bus_wdata[LO_W-1:0]),
    .cmp_q   (cmp_q),
    .en_q    (en_q),
    .flag_q  (flag_q)
  );

  tct_regif #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .LO_W(LO_W), .HI_W(HI_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .cmp_q     (cmp_q),
    .en_q      (en_q),
    .flag_q    (flag_q),
    .ctl_wr    (ctl_wr),
    .cmp_wr    (cmp_wr),
    .bus_rdata (bus_rdata)
  );

  assign irq = flag_q;
endmodule

// File: rtl/tct_chk.sv
module tct_chk
  import tct_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32,
  parameter int LO_W   = 32,
  parameter int HI_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              clr_bit,
  input logic              bus_rd,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              irq,
  input logic [LO_W-1:0]   cnt_lo,
  input logic [HI_W-1:0]   cnt_hi,
  input logic [LO_W-1:0]   cmp_q,
  input logic              en_q
);
  localparam int CNT_W = LO_W + HI_W;

  logic mapped;
  logic clr_wr;
  logic hit_now;

  assign mapped  = (bus_addr == ADDR_W'(OFF_CTL)) || (bus_addr == ADDR_W'(OFF_LO)) ||
                   (bus_addr == ADDR_W'(OFF_HI))  || (bus_addr == ADDR_W'(OFF_CMP));
  assign clr_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_CTL)) && clr_bit;
  assign hit_now = tick_en && en_q && (cnt_lo == cmp_q);

  // R2: one count per ticking cycle, carry included
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + CNT_W'(1)));

  // R2: counter holds without a tick
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable({cnt_hi, cnt_lo}));

  // R3: read data holds between reads
  a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R6 and R9: a qualifying match leaves the interrupt high, even against a clear
  a_r9_hit_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |=> irq);

  // R7: no new match while compare is disabled
  a_r7_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !en_q) |=> !irq);

  // R8: interrupt is sticky until a clearing write
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  // R11: unmapped reads return zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> (bus_rdata == '0));
endmodule

bind tick_compare_timer tct_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .LO_W(LO_W), .HI_W(HI_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick_en   (tick_en),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .clr_bit   (bus_wdata[0]),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi),
  .cmp_q     (cmp_q),
  .en_q      (en_q)
);

// File: tb/tick_compare_timer_tb.sv
`timescale 1ns/1ps
module tick_compare_timer_tb;
  localparam int LO_W = 8;
  localparam int HI_W = 4;
  localparam int ADDR_W = 8;
  localparam int BUS_W = 32;
  localparam int CW = LO_W + HI_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_en = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [BUS_W-1:0]  bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic [BUS_W-1:0]  bus_rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;

  logic [CW-1:0]   m_cnt = '0;
  logic [LO_W-1:0] m_cmp = '0;
  logic            m_en = 1'b0;
  logic            m_flag = 1'b0;

  always #2 clk = ~clk;

  tick_compare_timer #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .LO_W(LO_W), .HI_W(HI_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00:   return {27'd0, m_en, 3'd0, m_flag};
      8'h04:   return 32'(m_cnt[LO_W-1:0]);
      8'h08:   return 32'(m_cnt[CW-1:LO_W]);
      8'h0C:   return 32'(m_cmp);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic r, input string req);
    logic [31:0] exp_rd;
    logic        hit;
    tick_en = t; bus_wr = w; bus_addr = a; bus_wdata = d; bus_rd = r;
    exp_rd = exp_read(a);
    @(posedge clk);
    hit = t && m_en && (m_cnt[LO_W-1:0] == m_cmp);
    m_flag = hit || (m_flag && !(w && a == 8'h00 && d[0]));
    if (w && a == 8'h00) m_en = d[4];
    if (w && a == 8'h0C) m_cmp = d[LO_W-1:0];
    if (t) m_cnt = m_cnt + 1'b1;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    if (r) check(req, bus_rdata, exp_rd);
    check("R8 irq follows flag", {31'd0, irq}, {31'd0, m_flag});
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    cyc(1'b0, 1'b0, a, 32'd0, 1'b1, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b0, 1'b1, a, d, 1'b0, "");
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'h00, 32'd0, 1'b0, "");
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    logic [LO_W-1:0] l;
    logic [HI_W-1:0] h;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    check("R1 rdata in reset", bus_rdata, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: all registers zero after reset
    rd(8'h00, "R1 ctl");
    rd(8'h04, "R1 lo");
    rd(8'h08, "R1 hi");
    rd(8'h0C, "R1 cmp");
    check("R1 cmp literal", bus_rdata, 32'd0);

    // R5: enable bit, reserved bits read zero
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, "R5 ctl all ones");
    check("R5 ctl literal", bus_rdata, 32'h10);
    wr(8'h00, 32'h0);
    rd(8'h00, "R5 ctl zero");

    // R4: compare width
    wr(8'h0C, 32'hDEAD_BEEF);
    rd(8'h0C, "R4 cmp");
    check("R4 cmp literal", bus_rdata, 32'hEF);

    // R11: counter writes and unmapped writes ignored
    wr(8'h04, 32'h55);
    wr(8'h08, 32'h7);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h03, 32'hFFFF_FFFF);
    rd(8'h04, "R11 lo after write");
    check("R11 lo literal", bus_rdata, 32'd0);
    rd(8'h08, "R11 hi after write");
    check("R11 hi literal", bus_rdata, 32'd0);
    rd(8'h10, "R11 unmapped read");
    rd(8'hFC, "R11 unmapped read high");
    rd(8'h0C, "R11 cmp untouched");
    check("R11 cmp literal", bus_rdata, 32'hEF);

    // R2 and R3: counting and read of low word
    tick(20);
    rd(8'h04, "R3 lo");
    check("R2 lo after 20 ticks", bus_rdata, 32'd20);
    rd(8'h08, "R3 hi");
    check("R3 rdata holds", bus_rdata, 32'd0);
    cyc(1'b0, 1'b0, 8'h04, 32'd0, 1'b0, "");
    check("R3 hold without read", bus_rdata, 32'd0);

    // R2: carry into high word
    while (m_cnt[LO_W-1:0] != '1) tick(1);
    h = m_cnt[CW-1:LO_W];
    tick(1);
    rd(8'h04, "R2 lo after carry");
    check("R2 lo wrapped", bus_rdata, 32'd0);
    rd(8'h08, "R2 hi after carry");
    check("R2 hi carried", bus_rdata, 32'(HI_W'(h + 1'b1)));

    // R6: match on the sixth tick
    l = m_cnt[LO_W-1:0];
    wr(8'h0C, 32'(LO_W'(l + 8'd5)));
    wr(8'h00, 32'h10);
    tick(5);
    check("R6 no match yet", {31'd0, irq}, 32'd0);
    tick(1);
    check("R6 match", {31'd0, irq}, 32'd1);

    // R8: sticky flag, write 0 ignored, write 1 clears
    repeat (3) cyc(1'b0, 1'b0, 8'h00, 32'd0, 1'b0, "");
    check("R8 sticky", {31'd0, irq}, 32'd1);
    wr(8'h00, 32'h10);
    check("R8 write zero keeps", {31'd0, irq}, 32'd1);
    wr(8'h00, 32'h11);
    check("R8 write one clears", {31'd0, irq}, 32'd0);

    // R9: match and clear on the same edge
    wr(8'h0C, 32'(m_cnt[LO_W-1:0]));
    cyc(1'b1, 1'b1, 8'h00, 32'h11, 1'b0, "");
    check("R9 hit beats clear", {31'd0, irq}, 32'd1);

    // R10: clear and disable in one write
    wr(8'h00, 32'h1);
    check("R10 flag cleared", {31'd0, irq}, 32'd0);
    rd(8'h00, "R10 ctl");
    check("R10 ctl literal", bus_rdata, 32'd0);

    // R7: no match while disabled
    l = m_cnt[LO_W-1:0];
    wr(8'h0C, 32'(LO_W'(l + 8'd3)));
    tick(10);
    check("R7 no match disabled", {31'd0, irq}, 32'd0);

    // R12: match recurs after a full low-word period
    l = m_cnt[LO_W-1:0];
    wr(8'h0C, 32'(LO_W'(l + 8'd2)));
    wr(8'h00, 32'h10);
    tick(3);
    check("R12 first match", {31'd0, irq}, 32'd1);
    wr(8'h00, 32'h11);
    tick(255);
    check("R12 not yet", {31'd0, irq}, 32'd0);
    tick(1);
    check("R12 recurs", {31'd0, irq}, 32'd1);

    // R2: full counter wrap
    wr(8'h00, 32'h1);
    while (m_cnt != '1) tick(1);
    rd(8'h08, "R2 hi all ones");
    check("R2 hi literal", bus_rdata, 32'hF);
    tick(1);
    rd(8'h04, "R2 lo full wrap");
    check("R2 lo zero", bus_rdata, 32'd0);
    rd(8'h08, "R2 hi full wrap");
    check("R2 hi zero", bus_rdata, 32'd0);

    // random phase: model checks every read and irq
    for (int i = 0; i < 4000; i++) begin
      logic        t, w, r;
      logic [7:0]  a;
      logic [31:0] d;
      logic [2:0]  pick;
      t = 1'($urandom % 2);
      w = (($urandom % 8) == 0);
      r = (($urandom % 4) == 0);
      pick = 3'($urandom % 6);
      case (pick)
        3'd0: a = 8'h00;
        3'd1: a = 8'h04;
        3'd2: a = 8'h08;
        3'd3: a = 8'h0C;
        default: a = 8'($urandom);
      endcase
      d = $urandom;
      cyc(t, w, a, d, r, "R3 random read");
    end

    finish_run();
  end
endmodule